// File: doc/BRIEF.md
# Edge-Sensing GPIO Port Controller

This block is an 8-bit general purpose I/O port that sits behind a simple synchronous register bus. Each pin has an output latch and a direction bit. When the direction bit is 1 the latch value drives the pin. A read of the data location returns, bit by bit, either the latch (for output pins) or the synchronized pin level (for input pins).

Every pin input passes through a two-flop synchronizer. An edge detector then compares the synchronized level with its value one clock earlier. A per-pin polarity bit picks whether a rising or a falling transition counts as active. An active edge sets a sticky flag, and software clears a flag by writing 1 to it. One registered interrupt line is high while any flag is set and its enable bit is also set. Only bit positions 7, 6, 2, 1 and 0 exist; positions 5 to 3 are tied off in every register.

Register map (3-bit word address):

| Address | Register |
|---|---|
| 0 | data latch |
| 1 | direction (1 = output) |
| 2 | polarity (1 = rising, 0 = falling) |
| 3 | interrupt enable |
| 4 | flags (write 1 to clear) |

Addresses 5 to 7 read 0 and ignore writes. A write takes effect at the clock edge where `bus_sel` and `bus_wr` are both high. A read is requested with `bus_sel` high and `bus_wr` low. `bus_rdata` is loaded at that edge and keeps its value until the next read.

Top module: `edge_gpio_port`

## Requirements
- R1: After reset the direction, polarity, enable and flag registers read 0, and `pin_out`, `pin_oe` and `irq` are 0.
- R2: `pin_out` equals the data latch and `pin_oe` equals the direction register, both restricted to the implemented positions (mask 0xC7).
- R3: A read of address 0 returns the latch bit where the direction bit is 1, and the synchronized pin level where it is 0.
- R4: Bit positions 5, 4 and 3 read 0 in every register, ignore writes, and an edge on those pins sets no flag.
- R5: With polarity bit 0 a falling edge sets the flag and a rising edge does not. With polarity bit 1 the reverse holds.
- R6: A flag stays set until a write to address 4 with a 1 in that bit. Writing 0 to a flag bit leaves it unchanged.
- R7: If an active edge is detected in the same cycle as a write-1 clear of that flag, the flag ends up set.
- R8: `irq` is the registered OR over all bits of (flag AND enable). With all enables 0, `irq` stays 0 whatever the flags.
- R9: For a pin change applied between clock edges, `irq` (with the bit enabled) is still 0 after the third following rising clock edge and is 1 after the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Pin levels, asynchronous |
| pin_out | output | 8 | Output latch driven to pins |
| pin_oe | output | 8 | Output enable per pin |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that bus strobes and write data are synchronous to `clk` and change only between its rising edges. They also assume that a read and a write never overlap, since `bus_wr` selects between the two. Pin levels are asynchronous by nature, so no assertion depends on them directly; the checks work on the synchronized and detected signals. The stimulus drives every input on the falling clock edge. It holds each pin level for at least three clocks before it reads back or changes that pin again, so every transition passes through the synchronizer as a single clean edge.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_DATA = 3'd0,
        ADDR_DIR  = 3'd1,
        ADDR_POL  = 3'd2,
        ADDR_EN   = 3'd3,
        ADDR_FLAG = 3'd4
    } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level,
    input  logic [WIDTH-1:0] rise_sel,
    output logic [WIDTH-1:0] edge_hit
);
    logic [WIDTH-1:0] level_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_d <= '0;
        else        level_d <= level;
    end

    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            always_comb begin
                if (rise_sel[b]) edge_hit[b] = level[b] & ~level_d[b];
                else             edge_hit[b] = ~level[b] & level_d[b];
            end
        end
    endgenerate
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int               WIDTH     = 8,
    parameter logic [WIDTH-1:0] IMPL_MASK = 8'hC7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pin_level,
    input  logic [WIDTH-1:0]  edge_hit,
    output logic [WIDTH-1:0]  data_q,
    output logic [WIDTH-1:0]  dir_q,
    output logic [WIDTH-1:0]  pol_q,
    output logic [WIDTH-1:0]  en_q,
    output logic [WIDTH-1:0]  flag_q,
    output logic              irq_q
);
    logic             wr_en;
    logic             rd_en;
    logic [WIDTH-1:0] wdata_m;
    logic [WIDTH-1:0] clr_mask;
    logic [WIDTH-1:0] flag_n;
    logic [WIDTH-1:0] rd_mux;

    assign wr_en    = bus_sel & bus_wr;
    assign rd_en    = bus_sel & ~bus_wr;
    assign wdata_m  = bus_wdata & IMPL_MASK;
    assign clr_mask = (wr_en && bus_addr == ADDR_FLAG) ? wdata_m : '0;
    // a detected edge overrides a clear in the same cycle
    assign flag_n   = ((flag_q & ~clr_mask) | edge_hit) & IMPL_MASK;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '0;
            pol_q  <= '0;
            en_q   <= '0;
        end else if (wr_en) begin
            case (bus_addr)
                ADDR_DATA: data_q <= wdata_m;
                ADDR_DIR:  dir_q  <= wdata_m;
                ADDR_POL:  pol_q  <= wdata_m;
                ADDR_EN:   en_q   <= wdata_m;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            flag_q <= flag_n;
            irq_q  <= |(flag_q & en_q);
        end
    end

    always_comb begin
        case (bus_addr)
            ADDR_DATA: rd_mux = (dir_q & data_q) | (~dir_q & pin_level);
            ADDR_DIR:  rd_mux = dir_q;
            ADDR_POL:  rd_mux = pol_q;
            ADDR_EN:   rd_mux = en_q;
            ADDR_FLAG: rd_mux = flag_q;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     bus_rdata <= '0;
        else if (rd_en) bus_rdata <= rd_mux & IMPL_MASK;
    end
endmodule

// File: rtl/edge_gpio_port.sv
module edge_gpio_port
    import gpio_pkg::*;
#(
    parameter int               WIDTH       = 8,
    parameter logic [WIDTH-1:0] IMPL_MASK   = 8'hC7,
    parameter int               SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_out,
    output logic [WIDTH-1:0]  pin_oe,
    output logic              irq
);
    logic [WIDTH-1:0] pin_level;
    logic [WIDTH-1:0] edge_raw;
    logic [WIDTH-1:0] edge_vec;
    logic [WIDTH-1:0] data_q;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] pol_q;
    logic [WIDTH-1:0] en_q;
    logic [WIDTH-1:0] flag_q;

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_level)
    );

    gpio_edge_detect #(.WIDTH(WIDTH)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (pin_level),
        .rise_sel (pol_q),
        .edge_hit (edge_raw)
    );

    assign edge_vec = edge_raw & IMPL_MASK;

    gpio_regs #(.WIDTH(WIDTH), .IMPL_MASK(IMPL_MASK)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_level (pin_level),
        .edge_hit  (edge_vec),
        .data_q    (data_q),
        .dir_q     (dir_q),
        .pol_q     (pol_q),
        .en_q      (en_q),
        .flag_q    (flag_q),
        .irq_q     (irq)
    );

    assign pin_out = data_q;
    assign pin_oe  = dir_q;
endmodule

// File: rtl/edge_gpio_port_chk.sv
module edge_gpio_port_chk
    import gpio_pkg::*;
#(
    parameter int               WIDTH     = 8,
    parameter logic [WIDTH-1:0] IMPL_MASK = 8'hC7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WIDTH-1:0]  bus_wdata,
    input logic [WIDTH-1:0]  pin_oe,
    input logic [WIDTH-1:0]  pin_out,
    input logic [WIDTH-1:0]  flag_q,
    input logic [WIDTH-1:0]  en_q,
    input logic [WIDTH-1:0]  edge_vec,
    input logic              irq
);
    // R2
    dir_to_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_sel && bus_wr && bus_addr == ADDR_DIR)
        |-> pin_oe == ($past(bus_wdata) & IMPL_MASK));

    // R4
    unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_q | en_q | pin_oe | pin_out) & ~IMPL_MASK) == '0);

    // R6
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(flag_q) & ~flag_q))
        |-> $past(bus_sel && bus_wr && bus_addr == ADDR_FLAG));

    // R7
    edge_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|$past(edge_vec)) |-> ((flag_q & $past(edge_vec)) == $past(edge_vec)));

    // R8
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en_q == '0) |-> !irq);
endmodule

bind edge_gpio_port edge_gpio_port_chk #(.WIDTH(WIDTH), .IMPL_MASK(IMPL_MASK)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pin_oe    (pin_oe),
    .pin_out   (pin_out),
    .flag_q    (flag_q),
    .en_q      (en_q),
    .edge_vec  (edge_vec),
    .irq       (irq)
);

// File: tb/edge_gpio_port_tb.sv
module edge_gpio_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pins = '0;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;
    logic       irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    localparam logic [2:0] A_DATA = 3'd0, A_DIR = 3'd1, A_POL = 3'd2,
                           A_EN = 3'd3, A_FLAG = 3'd4;

    always #4 clk = ~clk;

    edge_gpio_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pins), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic set_pins(input logic [7:0] v);
        pins = v;
        cyc(4);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(A_DIR, d);  chk("R1 dir", d, 8'h00);
        rd(A_POL, d);  chk("R1 pol", d, 8'h00);
        rd(A_EN, d);   chk("R1 en", d, 8'h00);
        rd(A_FLAG, d); chk("R1 flag", d, 8'h00);
        chk("R1 pin_out", pin_out, 8'h00);
        chk("R1 pin_oe", pin_oe, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_output();
        logic [7:0] d;
        wr(A_DIR, 8'hFF);
        wr(A_DATA, 8'hA5);
        chk("R2 pin_oe", pin_oe, 8'hC7);
        chk("R2 pin_out", pin_out, 8'h85);
        rd(A_DATA, d); chk("R3 latch read", d, 8'h85);
        rd(A_DIR, d);  chk("R4 dir masked", d, 8'hC7);
        wr(A_EN, 8'hFF);
        rd(A_EN, d);   chk("R4 en masked", d, 8'hC7);
        wr(A_EN, 8'h00);
        rd(A_POL + 3'd3, d); chk("R4 unused address", d, 8'h00);
    endtask

    task automatic t_readmux();
        logic [7:0] d;
        wr(A_DIR, 8'h0F);
        wr(A_DATA, 8'hFF);
        set_pins(8'h40);
        rd(A_DATA, d); chk("R3 mixed read", d, 8'h47);
        wr(A_DIR, 8'h00);
        wr(A_DATA, 8'h00);
        set_pins(8'h00);
        wr(A_FLAG, 8'hFF);
        rd(A_FLAG, d); chk("R6 cleared", d, 8'h00);
    endtask

    task automatic t_polarity();
        logic [7:0] d;
        wr(A_POL, 8'h01);
        set_pins(8'h03);
        rd(A_FLAG, d); chk("R5 rising", d, 8'h01);
        wr(A_FLAG, 8'hFF);
        set_pins(8'h00);
        rd(A_FLAG, d); chk("R5 falling", d, 8'h02);
        wr(A_FLAG, 8'hFF);
        wr(A_POL, 8'h00);
    endtask

    task automatic t_sticky();
        logic [7:0] d;
        set_pins(8'h40);
        set_pins(8'h00);
        cyc(5);
        rd(A_FLAG, d); chk("R6 sticky", d, 8'h40);
        wr(A_FLAG, 8'h00);
        rd(A_FLAG, d); chk("R6 write zero", d, 8'h40);
        wr(A_FLAG, 8'h02);
        rd(A_FLAG, d); chk("R6 other bit", d, 8'h40);
        wr(A_FLAG, 8'h40);
        rd(A_FLAG, d); chk("R6 clear", d, 8'h00);
    endtask

    task automatic t_unimpl();
        logic [7:0] d;
        wr(A_EN, 8'hFF);
        set_pins(8'h10);
        set_pins(8'h00);
        rd(A_FLAG, d); chk("R4 pin4 flag", d, 8'h00);
        chk("R4 pin4 irq", {7'd0, irq}, 8'h00);
        wr(A_EN, 8'h00);
    endtask

    task automatic t_irq();
        logic [7:0] d;
        set_pins(8'h80);
        set_pins(8'h00);
        rd(A_FLAG, d); chk("R8 flag set", d, 8'h80);
        chk("R8 irq disabled", {7'd0, irq}, 8'h00);
        wr(A_EN, 8'h80);
        cyc(2);
        chk("R8 irq enabled", {7'd0, irq}, 8'h01);
        wr(A_FLAG, 8'h80);
        cyc(2);
        chk("R8 irq after clear", {7'd0, irq}, 8'h00);
        wr(A_EN, 8'h00);
    endtask

    task automatic t_latency();
        wr(A_POL, 8'h01);
        wr(A_EN, 8'h01);
        pins = 8'h01;
        cyc(3);
        chk("R9 irq after 3 edges", {7'd0, irq}, 8'h00);
        cyc(1);
        chk("R9 irq after 4 edges", {7'd0, irq}, 8'h01);
        wr(A_EN, 8'h00);
        wr(A_FLAG, 8'hFF);
        set_pins(8'h00);
        wr(A_POL, 8'h00);
    endtask

    task automatic t_setwins();
        logic [7:0] d;
        wr(A_POL, 8'h02);
        wr(A_FLAG, 8'hFF);
        pins = 8'h02;
        cyc(2);
        wr(A_FLAG, 8'h02);
        rd(A_FLAG, d); chk("R7 set beats clear", d, 8'h02);
        wr(A_FLAG, 8'h02);
        rd(A_FLAG, d); chk("R7 later clear", d, 8'h00);
        set_pins(8'h00);
        wr(A_POL, 8'h00);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        t_reset();
        t_output();
        t_readmux();
        t_polarity();
        t_sticky();
        t_unimpl();
        t_irq();
        t_latency();
        t_setwins();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule